// File: doc/BRIEF.md
# Serial wire debug target engine

This block is the target end of a two-wire synchronous debug link. The host supplies the clock and shares one bidirectional data line with the target. The block samples that line on rising clock edges and hunts for a start bit. It then collects an 8-bit request packet and checks it. If the packet is good, it asks a register-side agent for a response.

The agent answers with a 3-bit acknowledge code. For a read, it also answers with a 32-bit word. The block returns the acknowledge to the host. It then sends the read word with its parity, or it receives the host's write word and its parity. Every field is shifted least-significant bit first.

Whenever ownership of the line changes hands, the block leaves the line undriven for a turnaround period. The pad is controlled through a separate output-enable pin. All driven values change on falling clock edges.

The register-side agent responds combinationally. The request pulse is high for the turnaround period that follows the request, and the response is captured at the end of that period.

Top module: `swd_target`

## Requirements
- R1: While reset is asserted, and after it is released until a request arrives, the output enable, the request pulse and the write pulse are all low.
- R2: A request is 8 bits, LSB first. Bit 0 is start (1). Bit 1 is the bank (0 debug port, 1 access port). Bit 2 is the direction (0 write, 1 read). Bits 4:3 are address bits A[3:2]. Bit 5 is parity. Bit 6 is stop (0). Bit 7 is park (1). For a good request, the request pulse is high for exactly the one clock period after the park bit is sampled, with the bank, direction and address on their outputs.
- R3: The target drops the request and returns to hunting for a start bit in three cases: the parity bit differs from the even parity of bits 1 to 4, the stop bit is 1, or the park bit is 0. In these cases no request pulse is raised and the line is never driven. The next good request is accepted normally.
- R4: After a good request, the line stays undriven for one turnaround period. The target then drives the agent's 3-bit acknowledge over three periods, LSB first. The codes are OK = 001, WAIT = 010 and FAULT = 100. The target never drives while the host drives.
- R5: For a read with OK, the target drives the 32-bit word LSB first right after the acknowledge, then one even-parity bit over the word. It then releases the line for one turnaround period before it hunts again.
- R6: For a write with OK, the line stays undriven for one turnaround period after the acknowledge. The target then samples 32 data bits LSB first and a parity bit. If the parity is even and correct, the write pulse is high for exactly one period with the word on the write data output.
- R7: A write whose data parity bit is wrong raises no write pulse.
- R8: With WAIT or FAULT there is no data phase. The line is released after the acknowledge, no write pulse is raised, and a new request is accepted after one turnaround period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| swclk | input | 1 | Link clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| swdio_in | input | 1 | Value seen on the data line |
| swdio_out | output | 1 | Value driven onto the data line when enabled |
| swdio_oe | output | 1 | Pad output enable |
| req_valid | output | 1 | One-period pulse for an accepted request |
| req_ap | output | 1 | Bank select of the last request (1 = access port) |
| req_rnw | output | 1 | Direction of the last request (1 = read) |
| req_addr | output | 2 | Address bits A[3:2] of the last request |
| rsp_ack | input | 3 | Acknowledge code from the agent, valid while req_valid is high |
| rsp_rdata | input | 32 | Read word from the agent, valid while req_valid is high |
| wr_valid | output | 1 | One-period write pulse after good write data |
| wr_data | output | 32 | Received write word |

## Verification
A wrong state in the sequencer shows at the pins within one bit period, in one of three ways:
- the output enable goes high during a turnaround, which collides with the host or the pull-up;
- an acknowledge or data bit is shifted by one position;
- a request pulse is missing or extra.

A parity-logic fault shows as a rejected good request, a missing write pulse, or a wrong read parity bit, visible at the end of that transaction. The sweeps cover every bank, direction, address and acknowledge combination, in both directions, so a fault confined to one decode path is still reached.

// File: rtl/swd_tgt_pkg.sv
`timescale 1ns/1ps
package swd_tgt_pkg;
    localparam int unsigned REQ_BITS = 8;
    localparam int unsigned ACK_BITS = 3;

    // request field positions (wire order, LSB first)
    localparam int unsigned RQ_START = 0;
    localparam int unsigned RQ_BANK  = 1;
    localparam int unsigned RQ_DIR   = 2;
    localparam int unsigned RQ_ADDR  = 3;
    localparam int unsigned RQ_PAR   = 5;
    localparam int unsigned RQ_STOP  = 6;
    localparam int unsigned RQ_PARK  = 7;

    localparam logic [ACK_BITS-1:0] ACK_OK    = 3'b001;
    localparam logic [ACK_BITS-1:0] ACK_WAIT  = 3'b010;
    localparam logic [ACK_BITS-1:0] ACK_FAULT = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ     = 3'd1,
        ST_TRN_REQ = 3'd2,
        ST_ACK     = 3'd3,
        ST_TRN_WR  = 3'd4,
        ST_WDATA   = 3'd5,
        ST_RDATA   = 3'd6,
        ST_TRN_END = 3'd7
    } swd_st_e;
endpackage

// File: rtl/swd_parity.sv
`timescale 1ns/1ps
module swd_parity #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] bits_i,
    output logic         par_o
);
    // even parity: the bit that makes the total count of ones even
    assign par_o = ^bits_i;
endmodule

// File: rtl/swd_req_check.sv
`timescale 1ns/1ps
module swd_req_check
    import swd_tgt_pkg::*;
(
    input  logic [REQ_BITS-1:0] pkt_i,
    output logic                ok_o,
    output logic                bank_o,
    output logic                dir_o,
    output logic [1:0]          addr_o
);
    localparam int unsigned HDR_W = RQ_PAR - RQ_BANK;

    logic par_calc;

    swd_parity #(.W(HDR_W)) hdr_par_i (
        .bits_i (pkt_i[RQ_PAR-1:RQ_BANK]),
        .par_o  (par_calc)
    );

    assign bank_o = pkt_i[RQ_BANK];
    assign dir_o  = pkt_i[RQ_DIR];
    assign addr_o = pkt_i[RQ_ADDR +: 2];
    assign ok_o   = pkt_i[RQ_START] & ~pkt_i[RQ_STOP] & pkt_i[RQ_PARK]
                  & (par_calc == pkt_i[RQ_PAR]);
endmodule

// File: rtl/swd_pad_drive.sv
`timescale 1ns/1ps
module swd_pad_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_d,
    input  logic dat_d,
    output logic oe_q,
    output logic dat_q
);
    // falling-edge stage: values launched half a period before the host samples
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            dat_q <= 1'b0;
        end else begin
            oe_q  <= oe_d;
            dat_q <= dat_d;
        end
    end
endmodule

// File: rtl/swd_target.sv
`timescale 1ns/1ps
module swd_target
    import swd_tgt_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned TRN_LEN = 1
) (
    input  logic              swclk,
    input  logic              rst_n,
    input  logic              swdio_in,
    output logic              swdio_out,
    output logic              swdio_oe,
    output logic              req_valid,
    output logic              req_ap,
    output logic              req_rnw,
    output logic [1:0]        req_addr,
    input  logic [2:0]        rsp_ack,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data
);
    localparam int unsigned CNT_MAX  = (DATA_W > TRN_LEN) ? DATA_W : TRN_LEN;
    localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] TRN_LAST = CNT_W'(TRN_LEN - 1);
    localparam logic [CNT_W-1:0] REQ_LAST = CNT_W'(REQ_BITS - 1);
    localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_BITS - 1);
    localparam logic [CNT_W-1:0] PAR_POS  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        swd_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic [REQ_BITS-2:0] rsh;
        logic [DATA_W-1:0]   dsh;
        logic                rpar;
        logic [2:0]          ack;
        logic                ack_ok;
        logic                bank;
        logic                dir;
        logic [1:0]          addr;
        logic                wr_vld;
    } state_t;

    state_t q, d;
    swd_st_e st_cur;

    logic [REQ_BITS-1:0] pkt;
    logic                pkt_ok, pkt_bank, pkt_dir;
    logic [1:0]          pkt_addr;
    logic                rd_par, wd_par;
    logic                oe_d, dat_d;

    assign pkt = {swdio_in, q.rsh};

    swd_req_check req_chk_i (
        .pkt_i  (pkt),
        .ok_o   (pkt_ok),
        .bank_o (pkt_bank),
        .dir_o  (pkt_dir),
        .addr_o (pkt_addr)
    );

    swd_parity #(.W(DATA_W)) rd_par_i (
        .bits_i (rsp_rdata),
        .par_o  (rd_par)
    );

    swd_parity #(.W(DATA_W)) wd_par_i (
        .bits_i (q.dsh),
        .par_o  (wd_par)
    );

    always_comb begin
        d        = q;
        d.wr_vld = 1'b0;
        oe_d     = 1'b0;
        dat_d    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (swdio_in) begin
                    d.st  = ST_REQ;
                    d.cnt = ONE;
                    d.rsh = {1'b1, {(REQ_BITS-2){1'b0}}};
                end
            end
            ST_REQ: begin
                d.rsh = pkt[REQ_BITS-1:1];
                if (q.cnt == REQ_LAST) begin
                    d.cnt = '0;
                    if (pkt_ok) begin
                        d.st   = ST_TRN_REQ;
                        d.bank = pkt_bank;
                        d.dir  = pkt_dir;
                        d.addr = pkt_addr;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_TRN_REQ: begin
                if (q.cnt == '0) begin
                    d.ack    = rsp_ack;
                    d.ack_ok = (rsp_ack == ACK_OK);
                    d.dsh    = rsp_rdata;
                    d.rpar   = rd_par;
                end
                if (q.cnt == TRN_LAST) begin
                    d.st  = ST_ACK;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_ACK: begin
                oe_d  = 1'b1;
                dat_d = q.ack[0];
                d.ack = q.ack >> 1;
                if (q.cnt == ACK_LAST) begin
                    d.cnt = '0;
                    if (!q.ack_ok)  d.st = ST_TRN_END;
                    else if (q.dir) d.st = ST_RDATA;
                    else            d.st = ST_TRN_WR;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_TRN_WR: begin
                if (q.cnt == TRN_LAST) begin
                    d.st  = ST_WDATA;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_WDATA: begin
                if (q.cnt == PAR_POS) begin
                    d.wr_vld = (swdio_in == wd_par);
                    d.st     = ST_IDLE;
                    d.cnt    = '0;
                end else begin
                    d.dsh = {swdio_in, q.dsh[DATA_W-1:1]};
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_RDATA: begin
                oe_d  = 1'b1;
                dat_d = (q.cnt == PAR_POS) ? q.rpar : q.dsh[0];
                if (q.cnt == PAR_POS) begin
                    d.st  = ST_TRN_END;
                    d.cnt = '0;
                end else begin
                    d.dsh = q.dsh >> 1;
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_TRN_END: begin
                if (q.cnt == TRN_LAST) begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge swclk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    swd_pad_drive pad_i (
        .clk   (swclk),
        .rst_n (rst_n),
        .oe_d  (oe_d),
        .dat_d (dat_d),
        .oe_q  (swdio_oe),
        .dat_q (swdio_out)
    );

    assign st_cur    = q.st;
    assign req_valid = (q.st == ST_TRN_REQ) && (q.cnt == '0);
    assign req_ap    = q.bank;
    assign req_rnw   = q.dir;
    assign req_addr  = q.addr;
    assign wr_valid  = q.wr_vld;
    assign wr_data   = q.dsh;
endmodule

// File: rtl/swd_target_chk.sv
`timescale 1ns/1ps
module swd_target_chk
    import swd_tgt_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input swd_st_e st,
    input logic    swdio_oe,
    input logic    req_valid,
    input logic    wr_valid
);
    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    p_req_after_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(st) == ST_REQ);

    p_drive_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        swdio_oe |-> (st == ST_ACK || st == ST_RDATA));

    p_ack_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK) |-> swdio_oe);

    p_trn_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRN_REQ || st == ST_TRN_WR || st == ST_TRN_END) |-> !swdio_oe);

    p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    p_wr_after_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(st) == ST_WDATA);
endmodule

bind swd_target swd_target_chk chk_i (
    .clk       (swclk),
    .rst_n     (rst_n),
    .st        (st_cur),
    .swdio_oe  (swdio_oe),
    .req_valid (req_valid),
    .wr_valid  (wr_valid)
);

// File: tb/swd_target_tb.sv
`timescale 1ns/1ps
module swd_target_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_oe = 1'b1;
    logic        host_bit = 1'b0;
    logic        swdio_in, swdio_out, swdio_oe;
    logic        req_valid, req_ap, req_rnw, wr_valid;
    logic [1:0]  req_addr;
    logic [2:0]  rsp_ack = 3'b001;
    logic [31:0] rsp_rdata = '0;
    logic [31:0] wr_data;

    int vectors = 0;
    int fails = 0;
    int clash = 0;
    bit done = 0;
    logic obs_oe, obs_dat, obs_req, obs_wr;

    always #10 clk = ~clk;

    // open-drain style line with pull-up
    assign swdio_in = swdio_oe ? swdio_out : (host_oe ? host_bit : 1'b1);

    swd_target dut_i (
        .swclk     (clk),
        .rst_n     (rst_n),
        .swdio_in  (swdio_in),
        .swdio_out (swdio_out),
        .swdio_oe  (swdio_oe),
        .req_valid (req_valid),
        .req_ap    (req_ap),
        .req_rnw   (req_rnw),
        .req_addr  (req_addr),
        .rsp_ack   (rsp_ack),
        .rsp_rdata (rsp_rdata),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bit period: host drives just after the falling edge, then observes
    task automatic tick(input logic en, input logic val);
        @(negedge clk);
        #2;
        host_oe  = en;
        host_bit = val;
        #1;
        obs_oe  = swdio_oe;
        obs_dat = swdio_out;
        obs_req = req_valid;
        obs_wr  = wr_valid;
        if (en && swdio_oe) clash++;
    endtask

    // kind: 0 good, 1 bad request parity, 2 bad stop, 3 bad park, 4 bad write parity
    task automatic xact(input logic ap, input logic rnw, input logic [1:0] addr,
                        input logic [2:0] ack, input logic [31:0] data, input int kind);
        logic [7:0]  pkt;
        logic [2:0]  got_ack;
        logic [32:0] got;
        logic        oe_all;
        pkt = {1'b1, (kind == 2) ? 1'b1 : 1'b0,
               ap ^ rnw ^ addr[0] ^ addr[1] ^ (kind == 1), addr[1], addr[0], rnw, ap, 1'b1};
        rsp_ack   = ack;
        rsp_rdata = data;
        for (int i = 0; i < 7; i++) tick(1'b1, pkt[i]);
        if (kind == 3) tick(1'b1, 1'b0);
        else           tick(1'b0, 1'b0);
        if (kind >= 1 && kind <= 3) begin
            for (int i = 0; i < 5; i++) begin
                tick(1'b1, 1'b0);
                chk("R3 rejected request stays silent", {62'd0, obs_req, obs_oe}, 64'd0);
            end
            return;
        end
        tick(1'b0, 1'b0);
        chk("R2 request pulse and fields", {59'd0, obs_req, req_ap, req_rnw, req_addr},
            {59'd0, 1'b1, ap, rnw, addr});
        chk("R4 turnaround after request", {63'd0, obs_oe}, 64'd0);
        oe_all = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(1'b0, 1'b0);
            got_ack[i] = obs_dat;
            oe_all &= obs_oe;
        end
        chk("R4 acknowledge bits", {60'd0, oe_all, got_ack}, {60'd0, 1'b1, ack});
        if (ack != 3'b001) begin
            tick(1'b0, 1'b0);
            chk("R8 line released after refusal", {63'd0, obs_oe}, 64'd0);
            tick(1'b1, 1'b0);
            chk("R8 no data phase or write", {62'd0, obs_oe, obs_wr}, 64'd0);
            return;
        end
        if (rnw) begin
            oe_all = 1'b1;
            for (int i = 0; i < 33; i++) begin
                tick(1'b0, 1'b0);
                got[i] = obs_dat;
                oe_all &= obs_oe;
            end
            chk("R5 read data and parity", {30'd0, oe_all, got},
                {30'd0, 1'b1, ^data, data});
            tick(1'b0, 1'b0);
            chk("R5 turnaround after read", {63'd0, obs_oe}, 64'd0);
            tick(1'b1, 1'b0);
            chk("R5 line idle after read", {63'd0, obs_oe}, 64'd0);
        end else begin
            tick(1'b0, 1'b0);
            chk("R6 turnaround before write data", {63'd0, obs_oe}, 64'd0);
            for (int i = 0; i < 32; i++) tick(1'b1, data[i]);
            tick(1'b1, (^data) ^ (kind == 4));
            tick(1'b1, 1'b0);
            if (kind == 4)
                chk("R7 bad write parity suppressed", {63'd0, obs_wr}, 64'd0);
            else
                chk("R6 write pulse and data", {31'd0, obs_wr, wr_data}, {31'd0, 1'b1, data});
            tick(1'b1, 1'b0);
            chk("R6 write pulse lasts one period", {63'd0, obs_wr}, 64'd0);
        end
    endtask

    initial begin
        logic [2:0]  codes [3];
        logic [31:0] pat;
        int n;
        codes[0] = 3'b001; codes[1] = 3'b010; codes[2] = 3'b100;
        repeat (3) @(posedge clk);
        #3;
        chk("R1 quiet during reset", {61'd0, swdio_oe, req_valid, wr_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        chk("R1 quiet after reset", {61'd0, obs_oe, obs_req, obs_wr}, 64'd0);

        n = 0;
        for (int ap = 0; ap < 2; ap++)
            for (int rnw = 0; rnw < 2; rnw++)
                for (int a = 0; a < 4; a++)
                    for (int k = 0; k < 3; k++) begin
                        n++;
                        pat = (32'h9E37_79B9 * n) ^ (32'h0101_0101 << (n % 8));
                        xact(ap[0], rnw[0], a[1:0], codes[k], pat, 0);
                        tick(1'b1, 1'b0);
                        tick(1'b1, 1'b0);
                    end

        xact(1'b1, 1'b1, 2'd3, 3'b001, 32'h0000_0000, 0); tick(1'b1, 1'b0);
        xact(1'b0, 1'b1, 2'd0, 3'b001, 32'hFFFF_FFFF, 0); tick(1'b1, 1'b0);
        xact(1'b1, 1'b0, 2'd1, 3'b001, 32'h8000_0001, 0); tick(1'b1, 1'b0);

        for (int kind = 1; kind <= 3; kind++) begin
            xact(1'b1, 1'b0, 2'd2, 3'b001, 32'hA5A5_0F0F, kind);
            xact(1'b0, 1'b1, 2'd1, 3'b001, 32'h1234_5678, 0);
            tick(1'b1, 1'b0);
        end

        xact(1'b1, 1'b0, 2'd3, 3'b001, 32'hDEAD_BEEF, 4); tick(1'b1, 1'b0);
        xact(1'b1, 1'b0, 2'd3, 3'b001, 32'h0BAD_F00D, 0); tick(1'b1, 1'b0);

        chk("R4 no drive while host drives", 64'(clash), 64'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule